// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block is an 8-bit up-counter. It counts either the instruction-cycle enable or edges on an external count pin. A 3-bit programmable prescaler sits either in front of the timer or in front of a free-running watchdog counter. Software chooses the count source, the pin edge, the owner of the prescaler and the division rate through static control inputs. Software loads the counter through a write strobe and reads it back continuously on `tmr_q`.

When the counter rolls over from 0xFF to 0x00 it raises a sticky interrupt flag, and only software clears that flag. The watchdog counts ticks from its own slow oscillator, which arrives as a clock-enable. After a fixed number of ticks that have passed the prescaler, the watchdog emits a one-cycle timeout pulse and drops a time-out status bit. A watchdog clear command raises that bit again. The division ratio depends on the owner: it is twice as large when the timer owns the prescaler as when the watchdog owns it.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After reset `tmr_q` is 0x00, `tmr_flag` is 0, `wdog_to` is 0 and `to_status` is 1.
- R2: With `src_sel`=0 the timer source event is `cyc_en`. With `src_sel`=1 it is an edge on `ext_pin`, and `cyc_en` is ignored. The pin passes through two synchronising flip-flops and a previous-value flop, so the counter changes on the third rising clock edge after the pin changes.
- R3: With `edge_sel`=0 only pin rising edges count. With `edge_sel`=1 only falling edges count. The other edge leaves `tmr_q` unchanged.
- R4: With `psc_to_wdog`=0 the timer advances once per 2^(`rate_code`+1) source events, which gives rates of 1:2 for code 0 up to 1:256 for code 7. The watchdog then counts every `wdo_tick`.
- R5: With `psc_to_wdog`=1 the timer advances on every source event. The watchdog advances once per 2^`rate_code` ticks of `wdo_tick`, which gives rates of 1:1 up to 1:128.
- R6: After `WDOG_TICKS` watchdog advances, `wdog_to` is high for exactly one cycle, `to_status` falls to 0 on the same edge, and the watchdog restarts from zero.
- R7: A `wdog_clr` strobe zeroes the watchdog counter, and also zeroes the prescaler when the watchdog owns it. It sets `to_status` to 1. A tick in the same cycle as the strobe is discarded.
- R8: A `tmr_wr` strobe loads `tmr_wdata` into `tmr_q` on the next edge and overrides any increment in that cycle. When the timer owns the prescaler, the strobe also zeroes the prescaler count.
- R9: An increment from 0xFF to 0x00 sets `tmr_flag`. A write never sets it. The flag holds until `flag_clr`, and a set in the same cycle as `flag_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per cycle |
| wdo_tick | input | 1 | Watchdog oscillator tick (clock-enable) |
| ext_pin | input | 1 | External count pin, asynchronous |
| src_sel | input | 1 | Timer source: 0 instruction cycle, 1 pin edges |
| edge_sel | input | 1 | Pin edge: 0 rising, 1 falling |
| psc_to_wdog | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| rate_code | input | 3 | Prescaler rate code |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| flag_clr | input | 1 | Clear the overflow flag |
| wdog_clr | input | 1 | Watchdog clear command |
| tmr_q | output | 8 | Timer value |
| tmr_flag | output | 1 | Overflow interrupt flag |
| wdog_to | output | 1 | Watchdog timeout pulse |
| to_status | output | 1 | Time-out status bit |

## Verification
A `cyc_en`, `tmr_wr` or `wdo_tick` pulse taken at one rising edge shows on `tmr_q`, `tmr_flag`, `wdog_to` or `to_status` right after that same edge. The bench drives each stimulus on a falling edge and samples on the next falling edge. A change on `ext_pin` needs three rising edges before it reaches `tmr_q`, so the pin task holds each level for four cycles before any check. Watchdog pulses last only one cycle, so the tick task samples `wdog_to` on every falling edge while it drives ticks, and then counts the pulses it saw.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;
  localparam int RATE_W = 3;
  localparam int PSC_W  = 8;

  typedef enum logic {
    OWN_TIMER = 1'b0,
    OWN_WDOG  = 1'b1
  } psc_owner_e;

  // Low-bit mask for the prescaler: all ones over log2(ratio) bits.
  // Timer ownership adds one octave to the ratio.
  function automatic logic [PSC_W-1:0] psc_mask(input logic [RATE_W-1:0] code,
                                                input logic to_wdog);
    logic [RATE_W:0] sh;
    logic [PSC_W:0]  span;
    sh   = {1'b0, code} + {{RATE_W{1'b0}}, ~to_wdog};
    span = ({{PSC_W{1'b0}}, 1'b1} << sh) - {{PSC_W{1'b0}}, 1'b1};
    return span[PSC_W-1:0];
  endfunction

  // The prescaler is due when every masked count bit is one.
  function automatic logic psc_due(input logic [PSC_W-1:0] cnt,
                                   input logic [PSC_W-1:0] mask);
    return (cnt & mask) == mask;
  endfunction
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_mode,
  output logic pin_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise_w;
  logic                   fall_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur     = sync_q[SYNC_STAGES-1];
  assign rise_w  = cur & ~prev_q;
  assign fall_w  = ~cur & prev_q;
  assign pin_evt = fall_mode ? fall_w : rise_w;
endmodule

// File: rtl/tmr_share_psc.sv
module tmr_share_psc
  import tmr_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              clr,
  input  logic [RATE_W-1:0] code,
  input  logic              to_wdog,
  output logic              fire
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;

  assign mask = psc_mask(code, to_wdog);
  assign fire = evt & ~clr & psc_due(cnt_q, mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (evt)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count8.sv
module tmr_count8 #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] q,
  output logic             flag,
  output logic             wrap
);
  localparam logic [TMR_W-1:0] TOP = {TMR_W{1'b1}};

  assign wrap = inc & ~wr & (q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr)     q <= wdata;
    else if (inc)    q <= q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (wrap)      flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_wdog_cnt.sv
module tmr_wdog_cnt #(
  parameter int WDOG_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic expire,
  output logic to_pulse,
  output logic status
);
  localparam int WD_W = (WDOG_TICKS > 2) ? $clog2(WDOG_TICKS) : 1;
  localparam logic [WD_W-1:0] LAST = WD_W'(WDOG_TICKS - 1);

  logic [WD_W-1:0] cnt_q;

  assign expire = inc & ~clr & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (expire)  cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_pulse <= 1'b0;
      status   <= 1'b1;
    end else begin
      to_pulse <= expire;
      if (clr)         status <= 1'b1;
      else if (expire) status <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
  import tmr_wdog_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WDOG_TICKS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              wdo_tick,
  input  logic              ext_pin,
  input  logic              src_sel,
  input  logic              edge_sel,
  input  logic              psc_to_wdog,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              tmr_wr,
  input  logic [TMR_W-1:0]  tmr_wdata,
  input  logic              flag_clr,
  input  logic              wdog_clr,
  output logic [TMR_W-1:0]  tmr_q,
  output logic              tmr_flag,
  output logic              wdog_to,
  output logic              to_status
);
  psc_owner_e owner;
  logic pin_evt;
  logic src_evt;
  logic psc_evt;
  logic psc_clr;
  logic psc_fire;
  logic tmr_inc;
  logic tmr_wrap;
  logic wd_inc;
  logic wd_expire;

  assign owner = psc_owner_e'(psc_to_wdog);

  tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_mode(edge_sel), .pin_evt(pin_evt)
  );

  assign src_evt = src_sel ? pin_evt : cyc_en;

  // Prescaler routing: the owner feeds it and resets it.
  assign psc_evt = (owner == OWN_WDOG) ? wdo_tick : src_evt;
  assign psc_clr = (owner == OWN_WDOG) ? wdog_clr : tmr_wr;

  tmr_share_psc psc_i (
    .clk(clk), .rst_n(rst_n), .evt(psc_evt), .clr(psc_clr),
    .code(rate_code), .to_wdog(psc_to_wdog), .fire(psc_fire)
  );

  assign tmr_inc = (owner == OWN_WDOG) ? src_evt : psc_fire;
  assign wd_inc  = (owner == OWN_WDOG) ? psc_fire : wdo_tick;

  tmr_count8 #(.TMR_W(TMR_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(tmr_inc), .wr(tmr_wr),
    .wdata(tmr_wdata), .flag_clr(flag_clr),
    .q(tmr_q), .flag(tmr_flag), .wrap(tmr_wrap)
  );

  tmr_wdog_cnt #(.WDOG_TICKS(WDOG_TICKS)) wd_i (
    .clk(clk), .rst_n(rst_n), .inc(wd_inc), .clr(wdog_clr),
    .expire(wd_expire), .to_pulse(wdog_to), .status(to_status)
  );
endmodule

// File: rtl/tmr_wdog_unit_chk.sv
module tmr_wdog_unit_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic             flag_clr,
  input logic             wdog_clr,
  input logic [TMR_W-1:0] tmr_q,
  input logic             tmr_flag,
  input logic             wdog_to,
  input logic             to_status,
  input logic             tmr_inc,
  input logic             tmr_wrap,
  input logic             wd_expire
);
  assert_wr_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> (tmr_q == $past(tmr_wdata)));

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && tmr_inc) |=> (tmr_q == $past(tmr_q) + 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && !tmr_inc) |=> $stable(tmr_q));

  assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> tmr_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !flag_clr) |=> tmr_flag);

  assert_expire_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (wdog_to && !to_status));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to |=> !wdog_to);

  assert_clr_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_clr |=> (to_status && !wdog_to));
endmodule

bind tmr_wdog_unit tmr_wdog_unit_chk #(.TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
  .flag_clr(flag_clr), .wdog_clr(wdog_clr), .tmr_q(tmr_q),
  .tmr_flag(tmr_flag), .wdog_to(wdog_to), .to_status(to_status),
  .tmr_inc(tmr_inc), .tmr_wrap(tmr_wrap), .wd_expire(wd_expire)
);

// File: tb/tmr_wdog_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_wdog_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, wdo_tick = 1'b0, ext_pin = 1'b0;
  logic       src_sel = 1'b0, edge_sel = 1'b0, psc_to_wdog = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic       tmr_wr = 1'b0, flag_clr = 1'b0, wdog_clr = 1'b0;
  logic [7:0] tmr_wdata = 8'h00;
  logic [7:0] tmr_q;
  logic       tmr_flag, wdog_to, to_status;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_wdog_unit #(.WDOG_TICKS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wdo_tick(wdo_tick),
    .ext_pin(ext_pin), .src_sel(src_sel), .edge_sel(edge_sel),
    .psc_to_wdog(psc_to_wdog), .rate_code(rate_code), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .flag_clr(flag_clr), .wdog_clr(wdog_clr),
    .tmr_q(tmr_q), .tmr_flag(tmr_flag), .wdog_to(wdog_to),
    .to_status(to_status)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cyc_en = 1'b1;
    end
    @(negedge clk) cyc_en = 1'b0;
  endtask

  task automatic write_tmr(input logic [7:0] v);
    @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = v; end
    @(negedge clk) tmr_wr = 1'b0;
  endtask

  task automatic pin_level(input logic v);
    @(negedge clk) ext_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_wclr();
    @(negedge clk) wdog_clr = 1'b1;
    @(negedge clk) wdog_clr = 1'b0;
  endtask

  task automatic run_wdo(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdog_to) pulses++;
      wdo_tick = 1'b1;
    end
    @(negedge clk);
    if (wdog_to) pulses++;
    wdo_tick = 1'b0;
    @(negedge clk);
    if (wdog_to) pulses++;
  endtask

  task automatic t_reset();
    check("R1 tmr_q", tmr_q, 0);
    check("R1 tmr_flag", tmr_flag, 0);
    check("R1 wdog_to", wdog_to, 0);
    check("R1 to_status", to_status, 1);
  endtask

  task automatic t_timer_rates();
    psc_to_wdog = 1'b0; src_sel = 1'b0;
    rate_code = 3'd0;
    write_tmr(8'h00);
    run_cyc(10);
    check("R4 rate 1:2", tmr_q, 5);
    rate_code = 3'd3;
    write_tmr(8'h00);
    run_cyc(63);
    check("R4 rate 1:16 before", tmr_q, 3);
    run_cyc(1);
    check("R4 rate 1:16", tmr_q, 4);
  endtask

  task automatic t_write_clears_psc();
    psc_to_wdog = 1'b0; src_sel = 1'b0; rate_code = 3'd1;
    write_tmr(8'h00);
    run_cyc(3);
    write_tmr(8'h10);
    run_cyc(3);
    check("R8 psc cleared by write", tmr_q, 8'h10);
    run_cyc(1);
    check("R8 count after write", tmr_q, 8'h11);
  endtask

  task automatic t_write_priority();
    psc_to_wdog = 1'b1; src_sel = 1'b0;
    write_tmr(8'h20);
    @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = 8'h55; cyc_en = 1'b1; end
    @(negedge clk) begin tmr_wr = 1'b0; cyc_en = 1'b0; end
    check("R8 write over increment", tmr_q, 8'h55);
    run_cyc(3);
    check("R5 timer 1:1 with wdog owner", tmr_q, 8'h58);
  endtask

  task automatic t_pin();
    psc_to_wdog = 1'b1; src_sel = 1'b1; edge_sel = 1'b0;
    write_tmr(8'h00);
    pin_level(1'b1);
    check("R2 pin rising counted", tmr_q, 1);
    pin_level(1'b0);
    check("R3 falling ignored in rise mode", tmr_q, 1);
    run_cyc(5);
    check("R2 cyc_en ignored for pin source", tmr_q, 1);
    pin_level(1'b1);
    check("R2 second rising", tmr_q, 2);
    edge_sel = 1'b1;
    write_tmr(8'h00);
    pin_level(1'b0);
    check("R3 falling counted", tmr_q, 1);
    pin_level(1'b1);
    check("R3 rising ignored in fall mode", tmr_q, 1);
    // latency: counter changes on third rising edge after pin change
    @(negedge clk) ext_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 not yet after two edges", tmr_q, 1);
    @(negedge clk);
    check("R2 counted on third edge", tmr_q, 2);
    src_sel = 1'b0; edge_sel = 1'b0;
  endtask

  task automatic t_overflow();
    psc_to_wdog = 1'b1; src_sel = 1'b0;
    write_tmr(8'hFF);
    check("R9 no flag before wrap", tmr_flag, 0);
    run_cyc(1);
    check("R9 wrap value", tmr_q, 0);
    check("R9 wrap sets flag", tmr_flag, 1);
    repeat (3) @(negedge clk);
    check("R9 flag holds", tmr_flag, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R9 flag cleared", tmr_flag, 0);
    write_tmr(8'hFF);
    write_tmr(8'h00);
    check("R9 write does not set flag", tmr_flag, 0);
    write_tmr(8'hFF);
    @(negedge clk) begin cyc_en = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin cyc_en = 1'b0; flag_clr = 1'b0; end
    check("R9 set wins over clear", tmr_flag, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_wdog_direct();
    int p;
    psc_to_wdog = 1'b0;
    pulse_wclr();
    run_wdo(3, p);
    check("R4 wdog no timeout at 3", p, 0);
    check("R6 status before timeout", to_status, 1);
    run_wdo(1, p);
    check("R6 one pulse at 4 ticks", p, 1);
    check("R6 status cleared", to_status, 0);
    pulse_wclr();
    check("R7 clear sets status", to_status, 1);
    run_wdo(3, p);
    @(negedge clk) begin wdog_clr = 1'b1; wdo_tick = 1'b1; end
    @(negedge clk) begin wdog_clr = 1'b0; wdo_tick = 1'b0; end
    run_wdo(3, p);
    check("R7 clear restarts watchdog", p, 0);
    run_wdo(1, p);
    check("R7 timeout after restart", p, 1);
    pulse_wclr();
  endtask

  task automatic t_wdog_psc();
    int p;
    psc_to_wdog = 1'b1; rate_code = 3'd1;
    pulse_wclr();
    run_wdo(7, p);
    check("R5 wdog 1:2 no timeout at 7", p, 0);
    run_wdo(1, p);
    check("R5 wdog 1:2 timeout at 8", p, 1);
    rate_code = 3'd0;
    pulse_wclr();
    run_wdo(4, p);
    check("R5 wdog 1:1 timeout at 4", p, 1);
    pulse_wclr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer_rates();
    t_write_clears_psc();
    t_write_priority();
    t_pin();
    t_overflow();
    t_wdog_direct();
    t_wdog_psc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule